// File: doc/BRIEF.md
# Down-Counting Timer with Compare-Driven Output

This block is a down-counting timer with an 8-bit prescaler, a reload (preload) register and a compare register. It drives one output pin, which can be three-stated. Software writes a control word through a small register port. The control word starts or stops the counter, freezes the whole module, selects one of four output behaviours and, optionally, a compare variant. In that variant, reaching zero and matching the compare value push the pin to opposite levels.

Three sticky event flags record what has happened: a timeout, a rising edge on the external gate and a compare match. Each flag has its own interrupt enable, and together they drive a summary interrupt. A status word combines the flags, the summary bit, the gate level, the run state, the pin level, the live compare match and the prescaler count. The status word is sampled into a snapshot that holds still while a read of it is in progress.

Register map (3-bit address): 0 control, 1 preload, 2 compare, 3 counter (read-only), 4 status. Control word bits: [0] run, [1] halt, [3:2] output behaviour (0 off, 1 flip, 2 low, 3 high), [4] compare variant, [5] timeout interrupt enable, [6] gate interrupt enable, [7] compare interrupt enable, [15:8] prescaler divide value. Control resets to 0xFF00.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the status word reads 0x00FF, the control word reads 0xFF00, and `tmr_out`, `tmr_oe` and `irq` are all low.
- R2: `tmr_oe` is low while the output behaviour field is 0 (off) and high for the other three codes.
- R3: A control write that leaves run = 0 and selects flip (1) or low (2) forces `tmr_out` to 0 on the next clock edge; selecting high (3) forces it to 1. A control write while running changes the pin level only through the counter events.
- R4: With flip selected and the counter running, `tmr_out` inverts on each timeout (counter stepping to 0x0000) when the compare variant is 0. When the compare variant is 1, it inverts on each compare event (counter stepping to the compare value) instead.
- R5: Without the compare variant, a running counter drives `tmr_out` to 0 (low) or to 1 (high) at the next timeout.
- R6: With the compare variant, low drives 0 at timeouts and 1 at compare events, and high does the reverse. When the compare value is 0x0000 both events coincide and the timeout level is driven.
- R7: While running, the counter steps once every divide+1 clocks. From 0x0000 it reloads the preload value. While stopped, it holds the preload value. Status bits [7:0] show the prescaler count, and bit 10 shows the run state.
- R8: Status bits 14 (timeout), 13 (gate) and 12 (compare) are set by their events and cleared by writing 1 to the same bit of address 4. An event in the cycle of a clear leaves the flag set.
- R9: While halt is 1, the counter and prescaler hold their values and status writes do not clear flags.
- R10: `irq` and status bit 15 are high exactly when some flag is set with its enable bit at 1.
- R11: While `reg_rd` is high with address 4, the returned status word does not change.
- R12: `gate_in` passes through a two-flop synchroniser. Status bit 11 shows the synchronised level, and a rising edge of it sets the gate flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (freezes the status snapshot) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| gate_in | input | 1 | Asynchronous external gate level |
| tmr_out | output | 1 | Timer output level |
| tmr_oe | output | 1 | Output enable for the timer pin |
| irq | output | 1 | Summary interrupt, active high |

## Verification
A wrong counter value or a missed reload moves the next timeout, and the pin shows this within one counter period as a flip or level change one or more cycles early or late. The bench therefore compares both the pin and the counter against a cycle-stepped model on every clock. A flag state that is wrong shows at `irq` in the same cycle and in the status word one cycle later. A snapshot that fails to hold shows as a changed status value between two reads of one held read strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    OM_OFF  = 2'd0,
    OM_FLIP = 2'd1,
    OM_LOW  = 2'd2,
    OM_HIGH = 2'd3
  } outmode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef struct packed {
    logic [PSC_W-1:0] div;
    logic             tc_ie;
    logic             tg_ie;
    logic             to_ie;
    logic             cmp_mode;
    outmode_e         mode;
    logic             halt;
    logic             run;
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_RST = 16'hFF00;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = tmr_pkg::PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick,
  output logic [PSC_W-1:0] psc_q
);
  logic [PSC_W-1:0] psc_d;

  always_comb begin
    psc_d = psc_q;
    tick  = 1'b0;
    if (!hold) begin
      if (!run) begin
        psc_d = div;
      end else if (psc_q == '0) begin
        psc_d = div;
        tick  = 1'b1;
      end else begin
        psc_d = psc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '1;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = tmr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] cnt_q,
  output logic             to_evt,
  output logic             cmp_evt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] step_val;
  logic             step;

  always_comb begin
    step     = run && !hold && tick;
    step_val = (cnt_q == '0) ? preload : cnt_q - 1'b1;
    to_evt   = step && (step_val == '0);
    cmp_evt  = step && (step_val == compare);
    match    = run && !hold && (cnt_q == compare);
    cnt_d    = cnt_q;
    if (!hold) begin
      if (!run)      cnt_d = preload;
      else if (step) cnt_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  outmode_e mode,
  input  logic     cmp_mode,
  input  logic     prog,
  input  outmode_e prog_mode,
  input  logic     to_evt,
  input  logic     cmp_evt,
  output logic     out_q,
  output logic     oe
);
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (prog) begin
      case (prog_mode)
        OM_FLIP, OM_LOW: out_d = 1'b0;
        OM_HIGH:         out_d = 1'b1;
        default:         out_d = out_q;
      endcase
    end else if (cmp_mode) begin
      case (mode)
        OM_FLIP: if (cmp_evt) out_d = !out_q;
        OM_LOW: begin
          if (to_evt)       out_d = 1'b0;
          else if (cmp_evt) out_d = 1'b1;
        end
        OM_HIGH: begin
          if (to_evt)       out_d = 1'b1;
          else if (cmp_evt) out_d = 1'b0;
        end
        default: out_d = out_q;
      endcase
    end else begin
      case (mode)
        OM_FLIP: if (to_evt) out_d = !out_q;
        OM_LOW:  if (to_evt) out_d = 1'b0;
        OM_HIGH: if (to_evt) out_d = 1'b1;
        default: out_d = out_q;
      endcase
    end
    oe = (mode != OM_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int PSC_W  = tmr_pkg::PSC_W,
  parameter int DATA_W = tmr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_in,
  input  logic              to_evt,
  input  logic              cmp_evt,
  input  logic              clr_we,
  input  logic [2:0]        clr_mask,
  input  logic [2:0]        ie,
  input  logic              rd_hold,
  input  logic              on,
  input  logic              out_lvl,
  input  logic              match,
  input  logic [PSC_W-1:0]  psc,
  output logic [2:0]        flags_q,
  output logic              irq,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] STAT_RST = DATA_W'({PSC_W{1'b1}});

  logic [2:0]        sync_q;
  logic [2:0]        flags_d;
  logic [DATA_W-1:0] stat_d;
  logic [DATA_W-1:0] live;
  logic              tg_evt;

  always_comb begin
    tg_evt  = sync_q[1] && !sync_q[2];
    flags_d = (flags_q & ~(clr_we ? clr_mask : 3'b000)) | {to_evt, tg_evt, cmp_evt};
    irq     = |(flags_q & ie);
    live    = {irq, flags_q, sync_q[1], on, out_lvl, match, psc};
    stat_d  = rd_hold ? stat_q : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      flags_q <= '0;
      stat_q  <= STAT_RST;
    end else begin
      sync_q  <= {sync_q[1:0], gate_in};
      flags_q <= flags_d;
      stat_q  <= stat_d;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              gate_in,
  output logic              tmr_out,
  output logic              tmr_oe,
  output logic              irq
);
  ctrl_t             ctrl_q, ctrl_d, ctrl_w;
  logic [CNT_W-1:0]  load_q, load_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [CNT_W-1:0]  cnt;
  logic [PSC_W-1:0]  psc;
  logic [2:0]        flags;
  logic [DATA_W-1:0] stat;
  logic              tick, to_evt, cmp_evt, match, on;
  logic              wr_ctrl, clr_we, prog, rd_hold;

  always_comb begin
    ctrl_w  = ctrl_t'(reg_wdata);
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    prog    = wr_ctrl && !ctrl_w.run && (ctrl_w.mode != OM_OFF);
    clr_we  = reg_wr && (reg_addr == A_STAT) && !ctrl_q.halt;
    rd_hold = reg_rd && (reg_addr == A_STAT);
    on      = ctrl_q.run && !ctrl_q.halt;
    ctrl_d  = wr_ctrl ? ctrl_w : ctrl_q;
    load_d  = (reg_wr && reg_addr == A_LOAD) ? reg_wdata[CNT_W-1:0] : load_q;
    cmp_d   = (reg_wr && reg_addr == A_CMP)  ? reg_wdata[CNT_W-1:0] : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .hold(ctrl_q.halt), .run(ctrl_q.run),
    .div(ctrl_q.div), .tick(tick), .psc_q(psc)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(ctrl_q.halt), .run(ctrl_q.run),
    .tick(tick), .preload(load_q), .compare(cmp_q), .cnt_q(cnt),
    .to_evt(to_evt), .cmp_evt(cmp_evt), .match(match)
  );

  tmr_outctl u_out (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .cmp_mode(ctrl_q.cmp_mode),
    .prog(prog), .prog_mode(ctrl_w.mode), .to_evt(to_evt), .cmp_evt(cmp_evt),
    .out_q(tmr_out), .oe(tmr_oe)
  );

  tmr_status #(.PSC_W(PSC_W), .DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .to_evt(to_evt),
    .cmp_evt(cmp_evt), .clr_we(clr_we), .clr_mask(reg_wdata[14:12]),
    .ie({ctrl_q.to_ie, ctrl_q.tg_ie, ctrl_q.tc_ie}), .rd_hold(rd_hold),
    .on(on), .out_lvl(tmr_out), .match(match), .psc(psc),
    .flags_q(flags), .irq(irq), .stat_q(stat)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      A_LOAD:  reg_rdata = DATA_W'(load_q);
      A_CMP:   reg_rdata = DATA_W'(cmp_q);
      A_CNT:   reg_rdata = DATA_W'(cnt);
      A_STAT:  reg_rdata = stat;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  c_mode,
  input logic        c_cmp,
  input logic        c_halt,
  input logic [2:0]  c_ie,
  input logic        wr_ctrl,
  input logic        w_run,
  input logic [1:0]  w_mode,
  input logic        rd_stat,
  input logic        tmr_out,
  input logic        tmr_oe,
  input logic        irq,
  input logic        to_evt,
  input logic        to_flag,
  input logic [15:0] cnt_q,
  input logic [15:0] stat_q
);
  // R2
  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mode == 2'd0) |-> !tmr_oe);
  // R3
  a_r3_prog_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_run && (w_mode == 2'd1 || w_mode == 2'd2)) |=> !tmr_out);
  a_r3_prog_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_run && w_mode == 2'd3) |=> tmr_out);
  // R6
  a_r6_low_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mode == 2'd2 && c_cmp && to_evt && !wr_ctrl) |=> !tmr_out);
  a_r6_high_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mode == 2'd3 && c_cmp && to_evt && !wr_ctrl) |=> tmr_out);
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> to_flag);
  // R9
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c_halt |=> $stable(cnt_q));
  // R10
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ie == 3'b000) |-> !irq);
  // R11
  a_r11_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> $stable(stat_q));
endmodule

bind cmp_timer tmr_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .c_mode(ctrl_q.mode), .c_cmp(ctrl_q.cmp_mode), .c_halt(ctrl_q.halt),
  .c_ie({ctrl_q.to_ie, ctrl_q.tg_ie, ctrl_q.tc_ie}),
  .wr_ctrl(wr_ctrl), .w_run(reg_wdata[0]), .w_mode(reg_wdata[3:2]),
  .rd_stat(rd_hold), .tmr_out(tmr_out), .tmr_oe(tmr_oe), .irq(irq),
  .to_evt(to_evt), .to_flag(flags[2]), .cnt_q(cnt), .stat_q(stat)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        gate_in = 1'b0;
  logic        tmr_out, tmr_oe, irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // scenario vectors: {mode[1:0], compare variant, preload[15:0], compare[15:0]}
  localparam logic [34:0] SCN [0:8] = '{
    {2'd1, 1'b0, 16'd3, 16'd1},
    {2'd1, 1'b1, 16'd4, 16'd2},
    {2'd2, 1'b0, 16'd3, 16'd0},
    {2'd2, 1'b1, 16'd5, 16'd2},
    {2'd3, 1'b0, 16'd2, 16'd1},
    {2'd3, 1'b1, 16'd5, 16'd3},
    {2'd2, 1'b1, 16'd3, 16'd0},
    {2'd3, 1'b1, 16'd3, 16'd0},
    {2'd1, 1'b1, 16'd2, 16'd0}
  };

  cmp_timer uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [15:0] cw(logic run, logic halt, logic [1:0] mode,
                                     logic cmp, logic [2:0] ie, logic [7:0] div);
    return {div, ie, cmp, mode, halt, run};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gate_in = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    do_reset();
    // R1 reset state
    peek(3'd4, v); check("R1 status", v, 16'h00FF);
    peek(3'd0, v); check("R1 control", v, 16'hFF00);
    check("R1 out", tmr_out, 0);
    check("R1 oe", tmr_oe, 0);
    check("R1 irq", irq, 0);

    // R3..R7 table walk against a cycle-stepped model
    for (int i = 0; i < 9; i++) begin
      logic [1:0] md; logic cm; logic [15:0] p, c, m_cnt, nx;
      logic m_out; int bad_out, bad_cnt;
      {md, cm, p, c} = SCN[i];
      do_reset();
      wr(3'd1, p);
      wr(3'd2, c);
      wr(3'd0, cw(0, 0, md, cm, 3'b000, 8'd0));
      m_out = (md == 2'd3);
      check("R3 stopped program level", tmr_out, m_out);
      wr(3'd0, cw(1, 0, md, cm, 3'b000, 8'd0));
      m_cnt = p; bad_out = 0; bad_cnt = 0;
      for (int k = 0; k < 24; k++) begin
        peek(3'd3, v);
        if (tmr_out !== m_out) bad_out++;
        if (v !== m_cnt) bad_cnt++;
        nx = (m_cnt == 0) ? p : m_cnt - 16'd1;
        if (cm) begin
          case (md)
            2'd1: if (nx == c) m_out = !m_out;
            2'd2: if (nx == 0) m_out = 0; else if (nx == c) m_out = 1;
            default: if (nx == 0) m_out = 1; else if (nx == c) m_out = 0;
          endcase
        end else begin
          case (md)
            2'd1: if (nx == 0) m_out = !m_out;
            2'd2: if (nx == 0) m_out = 0;
            default: if (nx == 0) m_out = 1;
          endcase
        end
        m_cnt = nx;
        @(negedge clk);
      end
      if (md == 2'd1)   check("R4 flip sequence mismatches", bad_out, 0);
      else if (cm)      check("R6 compare-variant mismatches", bad_out, 0);
      else              check("R5 timeout level mismatches", bad_out, 0);
      check("R7 counter sequence mismatches", bad_cnt, 0);
    end

    // R2 output enable
    do_reset();
    wr(3'd0, cw(0, 0, 2'd1, 0, 3'b000, 8'd0));
    check("R2 oe flip", tmr_oe, 1);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b000, 8'd0));
    check("R2 oe off", tmr_oe, 0);

    // R3/R5 running mode change: no immediate effect, low at timeout
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd0, cw(0, 0, 2'd3, 0, 3'b000, 8'd0));
    wr(3'd0, cw(1, 0, 2'd3, 0, 3'b000, 8'd0));
    wr(3'd0, cw(1, 0, 2'd2, 0, 3'b000, 8'd0));
    check("R3 running write keeps level", tmr_out, 1);
    for (int k = 0; k < 10; k++) begin
      peek(3'd3, v);
      if (v == 16'd1) check("R5 high before timeout", tmr_out, 1);
      if (v == 16'd0) begin check("R5 low at timeout", tmr_out, 0); break; end
      @(negedge clk);
    end

    // R7 prescaler divide and status fields
    do_reset();
    wr(3'd1, 16'd100);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b000, 8'd2));
    wr(3'd0, cw(1, 0, 2'd0, 0, 3'b000, 8'd2));
    repeat (10) @(negedge clk);
    peek(3'd3, v); check("R7 count after divide-by-3", v, 16'd97);
    peek(3'd4, v); check("R7 prescaler field", v[7:0], 8'd2);
    check("R7 run bit", v[10], 1);

    // R8/R10 flags, set-wins, masking
    do_reset();
    wr(3'd1, 16'd0);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b001, 8'd0));
    wr(3'd0, cw(1, 0, 2'd0, 0, 3'b001, 8'd0));
    repeat (3) @(negedge clk);
    check("R10 irq on enabled flag", irq, 1);
    wr(3'd4, 16'h4000);
    check("R8 set wins over clear", irq, 1);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b000, 8'd0));
    check("R10 irq masked", irq, 0);
    @(negedge clk);
    peek(3'd4, v);
    check("R8 flag held", v[14], 1);
    check("R10 status irq bit masked", v[15], 0);
    wr(3'd4, 16'h4000);
    @(negedge clk);
    peek(3'd4, v); check("R8 flag cleared", v[14], 0);

    // R9 halt
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b000, 8'd0));
    wr(3'd0, cw(1, 0, 2'd0, 0, 3'b000, 8'd0));
    repeat (5) @(negedge clk);
    wr(3'd0, cw(1, 1, 2'd0, 0, 3'b000, 8'd0));
    peek(3'd3, v);
    repeat (4) @(negedge clk);
    peek(3'd3, v2); check("R9 counter frozen", v2, v);
    wr(3'd4, 16'h4000);
    @(negedge clk);
    peek(3'd4, v); check("R9 clear ignored", v[14], 1);

    // R11 snapshot hold
    do_reset();
    wr(3'd1, 16'd1000);
    wr(3'd0, cw(0, 0, 2'd0, 0, 3'b000, 8'd3));
    wr(3'd0, cw(1, 0, 2'd0, 0, 3'b000, 8'd3));
    reg_addr = 3'd4; reg_rd = 1'b1;
    @(negedge clk);
    peek(3'd4, v);
    repeat (6) @(negedge clk);
    peek(3'd4, v2); check("R11 snapshot stable", v2, v);
    reg_rd = 1'b0;

    // R12 gate synchroniser
    do_reset();
    gate_in = 1'b1;
    @(negedge clk);
    peek(3'd4, v); check("R12 level not yet seen", v[11], 0);
    repeat (2) @(negedge clk);
    peek(3'd4, v); check("R12 level seen", v[11], 1);
    @(negedge clk);
    peek(3'd4, v); check("R12 gate flag", v[13], 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule